// File: doc/BRIEF.md
# Dual-Lane Serial ADC Readout Controller

This block runs a two-channel successive-approximation converter that has a serial readout, and turns its output into parallel words. It drives an active-low convert line. The converter samples its input while the line is high and converts after the line falls. Once the conversion wait is over, the block drives sixteen serial clock pulses. The converter sends back a delayed copy of that clock, and its two data lanes change in step with the copy. The block shifts both lanes in on the returned clock, most significant bit first. The finished pair of words then crosses into the system clock domain, where each word appears with a one-cycle valid pulse.

The converter has a latency of one conversion, so each readout carries the result of the conversion before it. A pulse on the start input begins a burst of back-to-back conversion cycles. The word from the first readout of every burst is stale: it is dropped and gets no valid pulse. A pulse on the stop input lets the cycle in progress finish its readout, and the sequencer then parks with the convert line high. Three inputs set the timing, each counted in system clock cycles: the acquisition time, the conversion wait and the serial clock half period.

Top module: `adc_dual_lane_reader`

## Requirements
- R1: While reset is held, and right after it is released, convN is 1, sclk is 0, dataValid is 0, and dataA and dataB are 0.
- R2: During a burst, convN stays low for cfgConvWait cycles. sclk then stays low for a further cfgSckHalf cycles before its first rising edge.
- R3: Each readout has exactly 16 sclk pulses. Each pulse is high for cfgSckHalf cycles and low for cfgSckHalf cycles. sclk is 0 whenever convN is 1.
- R4: A rising edge of echoClk samples sdoA and sdoB. The first of the 16 samples is bit 15 of the word and the last is bit 0. dataA and dataB change only in the cycle in which dataValid is 1.
- R5: dataValid is a pulse one cycle wide. It fires once for each readout that is not suppressed.
- R6: The first readout after each start is suppressed. The word from readout k (k of 2 or more) is the result of conversion k-1, so a burst of n readouts gives n-1 valid words.
- R7: After each readout convN returns to 1 for exactly cfgAcqHigh cycles and then falls again, with no further start needed.
- R8: After stop, the cycle in progress completes its full readout. convN then stays at 1 and sclk stays at 0 until the next start.
- R9: A configuration value of 0 behaves like a value of 1.
- R10: A start pulse during a running burst has no effect on timing or on word suppression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a burst from idle |
| stop | input | 1 | Pulse that ends the burst after the current readout |
| cfgAcqHigh | input | CW | convN high time in cycles |
| cfgConvWait | input | CW | Conversion wait in cycles |
| cfgSckHalf | input | CW | sclk half period in cycles |
| convN | output | 1 | Active-low convert strobe |
| sclk | output | 1 | Serial clock to the converter |
| echoClk | input | 1 | Clock returned by the converter |
| sdoA | input | 1 | Serial data, lane A |
| sdoB | input | 1 | Serial data, lane B |
| dataA | output | WORD | Parallel word, lane A |
| dataB | output | WORD | Parallel word, lane B |
| dataValid | output | 1 | One-cycle flag for a new word pair |

## Verification
The assertions rely on four things about the inputs:
- echoClk is a copy of sclk delayed by less than one system cycle, so exactly 16 echo edges arrive in each readout.
- Successive transfer toggles reach the system domain many cycles apart.
- The configuration inputs change only while the block is idle.
- stop is never raised together with start.

The bench converter model echoes sclk after a fixed 3 ns delay and shifts out the previous conversion's value. The bench changes the configuration only between bursts and issues stop only after a convert fall.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_READ
  } seqState_t;

  typedef struct packed {
    logic burstStart;
  } ctrlStrobes_t;
endpackage

// File: rtl/adcr_ctrl.sv
module adcr_ctrl
  import adcr_pkg::*;
#(
  parameter int WORD = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          stop,
  input  logic [CW-1:0] cfgAcqHigh,
  input  logic [CW-1:0] cfgConvWait,
  input  logic [CW-1:0] cfgSckHalf,
  output logic          convN,
  output logic          sclk,
  output ctrlStrobes_t  strobes
);
  localparam int HCW = $clog2(2 * WORD) + 1;
  localparam logic [HCW-1:0] LAST_HALF = HCW'(2 * WORD - 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  seqState_t state;
  logic [CW-1:0] cnt;
  logic [HCW-1:0] halfCnt;
  logic phase;
  logic stopReq;
  logic [CW-1:0] acqLim, waitLim, halfLim;

  assign acqLim  = (cfgAcqHigh == '0) ? ONE : cfgAcqHigh;
  assign waitLim = (cfgConvWait == '0) ? ONE : cfgConvWait;
  assign halfLim = (cfgSckHalf == '0) ? ONE : cfgSckHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt <= '0;
      halfCnt <= '0;
      phase <= 1'b0;
      stopReq <= 1'b0;
      strobes <= '0;
    end else begin
      strobes.burstStart <= 1'b0;
      if (stop && state != ST_IDLE) stopReq <= 1'b1;
      case (state)
        ST_IDLE: begin
          stopReq <= 1'b0;
          if (start && !stop) begin
            state <= ST_ACQ;
            cnt <= '0;
            strobes.burstStart <= 1'b1;
          end
        end
        ST_ACQ: begin
          if (cnt == acqLim - ONE) begin
            state <= ST_CONV;
            cnt <= '0;
          end else cnt <= cnt + ONE;
        end
        ST_CONV: begin
          if (cnt == waitLim - ONE) begin
            state <= ST_READ;
            cnt <= '0;
            halfCnt <= '0;
            phase <= 1'b0;
          end else cnt <= cnt + ONE;
        end
        ST_READ: begin
          if (cnt == halfLim - ONE) begin
            cnt <= '0;
            phase <= ~phase;
            if (halfCnt == LAST_HALF) begin
              halfCnt <= '0;
              state <= (stopReq || stop) ? ST_IDLE : ST_ACQ;
            end else halfCnt <= halfCnt + HCW'(1);
          end else cnt <= cnt + ONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign convN = (state == ST_IDLE) || (state == ST_ACQ);
  assign sclk = phase;

  // checker state: rising sclk edges seen while convN is low
  logic sckQ;
  logic [HCW-1:0] riseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      riseCnt <= '0;
    end else begin
      sckQ <= sclk;
      if (convN) riseCnt <= '0;
      else if (sclk && !sckQ) riseCnt <= riseCnt + HCW'(1);
    end
  end

  AST_SCK_ONLY_CONV_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !convN); // R3
  AST_PULSES_PER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convN) |-> riseCnt == HCW'(WORD)); // R3
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.burstStart |-> $past(state) == ST_IDLE); // R10
endmodule

// File: rtl/adcr_capture.sv
module adcr_capture
  import adcr_pkg::*;
#(
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  logic            echoClk,
  input  logic            sdoA,
  input  logic            sdoB,
  output logic [WORD-1:0] dataA,
  output logic [WORD-1:0] dataB,
  output logic            dataValid
);
  localparam int BW = $clog2(WORD);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD - 1);

  // echo clock domain
  logic [WORD-2:0] shA, shB;
  logic [WORD-1:0] holdA, holdB;
  logic [BW-1:0] bitCnt;
  logic xferTog;

  always_ff @(posedge echoClk or negedge rstN) begin
    if (!rstN) begin
      shA <= '0;
      shB <= '0;
      holdA <= '0;
      holdB <= '0;
      bitCnt <= '0;
      xferTog <= 1'b0;
    end else begin
      shA <= {shA[WORD-3:0], sdoA};
      shB <= {shB[WORD-3:0], sdoB};
      if (bitCnt == LAST_BIT) begin
        bitCnt <= '0;
        holdA <= {shA, sdoA};
        holdB <= {shB, sdoB};
        xferTog <= ~xferTog;
      end else bitCnt <= bitCnt + BW'(1);
    end
  end

  // system clock domain
  logic [2:0] syncTog;
  logic xferPulse;
  logic skipNext;

  assign xferPulse = syncTog[2] ^ syncTog[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncTog <= '0;
      skipNext <= 1'b1;
      dataA <= '0;
      dataB <= '0;
      dataValid <= 1'b0;
    end else begin
      syncTog <= {syncTog[1:0], xferTog};
      dataValid <= xferPulse && !skipNext;
      if (xferPulse && !skipNext) begin
        dataA <= holdA;
        dataB <= holdB;
      end
      if (strobes.burstStart) skipNext <= 1'b1;
      else if (xferPulse) skipNext <= 1'b0;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid); // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> ($stable(dataA) && $stable(dataB))); // R4
  AST_XFER_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    xferPulse |=> !xferPulse); // R5
endmodule

// File: rtl/adc_dual_lane_reader.sv
module adc_dual_lane_reader
  import adcr_pkg::*;
#(
  parameter int WORD = 16,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            stop,
  input  logic [CW-1:0]   cfgAcqHigh,
  input  logic [CW-1:0]   cfgConvWait,
  input  logic [CW-1:0]   cfgSckHalf,
  output logic            convN,
  output logic            sclk,
  input  logic            echoClk,
  input  logic            sdoA,
  input  logic            sdoB,
  output logic [WORD-1:0] dataA,
  output logic [WORD-1:0] dataB,
  output logic            dataValid
);
  ctrlStrobes_t strobes;

  adcr_ctrl #(.WORD(WORD), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop),
    .cfgAcqHigh(cfgAcqHigh), .cfgConvWait(cfgConvWait), .cfgSckHalf(cfgSckHalf),
    .convN(convN), .sclk(sclk), .strobes(strobes)
  );

  adcr_capture #(.WORD(WORD)) uCap (
    .clk(clk), .rstN(rstN), .strobes(strobes), .echoClk(echoClk),
    .sdoA(sdoA), .sdoB(sdoB), .dataA(dataA), .dataB(dataB), .dataValid(dataValid)
  );
endmodule

// File: tb/sim_adc_dual_lane_reader.sv
`timescale 1ns/1ps
module sim_adc_dual_lane_reader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic [7:0] cfgAcqHigh = 8'd1, cfgConvWait = 8'd1, cfgSckHalf = 8'd1;
  logic convN, sclk, dataValid;
  logic echoClk = 1'b0;
  logic sdoA, sdoB;
  logic [15:0] dataA, dataB;

  always #2.5 clk = ~clk;

  adc_dual_lane_reader u0 (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop),
    .cfgAcqHigh(cfgAcqHigh), .cfgConvWait(cfgConvWait), .cfgSckHalf(cfgSckHalf),
    .convN(convN), .sclk(sclk), .echoClk(echoClk), .sdoA(sdoA), .sdoB(sdoB),
    .dataA(dataA), .dataB(dataB), .dataValid(dataValid)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // converter model
  logic [15:0] convA = 16'h0, convB = 16'h0, outA = 16'h0, outB = 16'h0;
  logic [15:0] qA[$], qB[$];
  bit firstOfBurst = 0;
  int convIdx = 0;
  assign sdoA = outA[15];
  assign sdoB = outB[15];

  function automatic logic [31:0] pickConv(input int idx);
    case (idx)
      0: return {16'h8000, 16'h0001};
      1: return {16'hFFFF, 16'h0000};
      2: return {16'hA5A5, 16'h5A5A};
      default: return $urandom;
    endcase
  endfunction

  always @(sclk) begin
    #3;
    echoClk = sclk;
  end

  always @(negedge echoClk) begin
    outA = outA << 1;
    outB = outB << 1;
  end

  always @(negedge convN) begin
    outA = convA;
    outB = convB;
    if (firstOfBurst) firstOfBurst = 0;
    else begin
      qA.push_back(convA);
      qB.push_back(convB);
    end
    {convA, convB} = pickConv(convIdx);
    convIdx++;
  end

  // timing monitor
  int expH = 1, expW = 1, expS = 1;
  int hiLen = 0, preLen = 0, highRun = 0, pulses = 0, falls = 0, validCnt = 0;
  bit measHi = 0, sckHi = 0, prevCnv = 1, prevSck = 0, validPrev = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (convN) begin
        if (!prevCnv) begin
          chk(pulses == 16, "R3 pulses per readout", pulses, 16);
          chk(preLen == expW + expS, "R2 wait before first sclk", preLen, expW + expS);
          hiLen = 0;
          sckHi = 0;
          measHi = 1;
        end
        hiLen++;
        if (sclk) sckHi = 1;
      end else begin
        if (prevCnv) begin
          if (measHi) chk(hiLen == expH && !sckHi, "R7 convN high time", hiLen, expH);
          preLen = 0;
          pulses = 0;
          highRun = 0;
          falls++;
        end
        if (sclk) begin
          if (!prevSck) pulses++;
          highRun++;
        end else begin
          if (prevSck) chk(highRun == expS, "R3 sclk high time", highRun, expS);
          highRun = 0;
          if (pulses == 0) preLen++;
        end
      end
      prevCnv = convN;
      prevSck = sclk;
      if (dataValid) begin
        validCnt++;
        if (validPrev) chk(0, "R5 valid wider than one cycle", 2, 1);
        if (qA.size() == 0) chk(0, "R6 valid with no expected word", 1, 0);
        else begin
          logic [31:0] expW32;
          expW32 = {qA.pop_front(), qB.pop_front()};
          chk({dataA, dataB} == expW32, "R4 captured words", {dataA, dataB}, expW32);
        end
      end
      validPrev = dataValid;
    end
  end

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic runBurst(input int h, input int w, input int s, input int n, input bit midStart);
    int target;
    @(negedge clk);
    cfgAcqHigh = 8'(h);
    cfgConvWait = 8'(w);
    cfgSckHalf = 8'(s);
    expH = eff(h);
    expW = eff(w);
    expS = eff(s);
    measHi = 0;
    validCnt = 0;
    firstOfBurst = 1;
    target = falls + n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (falls < target) begin
      @(negedge clk);
      if (midStart && falls == target - n + 1) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        midStart = 0;
      end
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (500) @(negedge clk);
    chk(falls == target, "R8 no convert after stop", falls, target);
    chk(convN == 1'b1 && sclk == 1'b0, "R8 parked idle", {convN, sclk}, 2'b10);
    chk(qA.size() == 0, "R6 all later words delivered", qA.size(), 0);
    chk(validCnt == n - 1, "R6 first word suppressed", validCnt, n - 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(convN == 1'b1 && sclk == 1'b0 && dataValid == 1'b0, "R1 reset outputs", {convN, sclk, dataValid}, 3'b100);
    chk(dataA == 16'h0 && dataB == 16'h0, "R1 reset data", {dataA, dataB}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(convN == 1'b1 && sclk == 1'b0 && dataValid == 1'b0, "R1 after release", {convN, sclk, dataValid}, 3'b100);
    runBurst(2, 3, 1, 4, 0);
    runBurst(0, 0, 0, 3, 0);   // R9
    runBurst(1, 1, 2, 1, 0);   // single readout, nothing valid
    runBurst(3, 2, 1, 5, 1);   // R10 mid-burst start
    for (int i = 0; i < 6; i++)
      runBurst($urandom_range(1, 5), $urandom_range(1, 5), $urandom_range(1, 4), $urandom_range(1, 5), i[0]);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule